// File: doc/BRIEF.md
# SPI Write-Enable and Status Controller

This block is the serial front end of a memory slave on a SPI bus (mode 0). After chip-select falls it shifts in an 8-bit opcode, MSB first, and decodes it. It keeps the write-enable latch and an 8-bit status register holding that latch, a write-protect-enable bit and a two-bit block-protect field. It returns the status on a status read and updates it on a status write.

Every write-class command is gated by the latch. When the latch is set, the array write, the serial-number write and the four nonvolatile special commands each produce a one-clock request pulse carrying the opcode to a downstream stub. When the latch is clear the command is dropped and the rest of the frame is ignored. A permitted write-class command clears the latch when its frame ends, so each write needs its own enable. The SPI pins are sampled in the `clk` domain and are assumed to be already synchronised, with each SCK level held for at least two `clk` cycles.

Top module: `spi_wel_ctrl`

## Requirements
- R1: After reset the status reads 0x00, `miso_oe` is 0 and `req_valid` is 0.
- R2: Opcode 0x06 sets the write-enable latch once its 8th bit is sampled. Opcode 0x04 clears the latch at the chip-select rising edge that ends its frame.
- R3: `miso_oe` is 0 while opcode bits are shifted in and whenever chip-select is high. After opcode 0x05, `miso` drives the status byte MSB first, changing on SCK falling edges. SCK is sampled on rising edges.
- R4: The status byte is laid out as follows. Bit 7 is write-protect-enable. Bits 3:2 are block-protect. Bit 1 is the write-enable latch. Bits 6:4 and bit 0 always read 0, and bit 0 = 0 means ready.
- R5: When the latch is set, opcode 0x01 followed by a full data byte loads bit 7 and bits 3:2 from that byte. The other data bits have no effect.
- R6: When the latch is clear, the write-class opcodes are ignored: 0x01 status write, 0x02 array write, 0xC2 serial-number write, 0x3C store, 0x60 recall, 0x59 autostore enable and 0x19 autostore disable. They change no status and issue no request, and the rest of the frame is ignored until chip-select goes high.
- R7: A permitted write-class command that completes clears the latch at the chip-select rising edge that ends its frame.
- R8: When the latch is set, opcodes 0x02, 0xC2, 0x3C, 0x60, 0x59 and 0x19 each give exactly one one-clock `req_valid` pulse, with `req_opcode` equal to the opcode.
- R9: A frame whose chip-select rises before all 8 opcode bits, or before all 8 status-write data bits, changes no state and leaves the latch as it was.
- R10: Unknown opcodes, and any bytes after a decoded opcode other than the status-read and status-write data bytes, are ignored until chip-select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for `miso` (0 = high impedance) |
| req_valid | output | 1 | One-clock request pulse for a permitted write or special command |
| req_opcode | output | 8 | Opcode that goes with `req_valid` |

## Verification
The assertions assume that `cs_n` and `sck` are synchronous to `clk` and change no more than once every two cycles, so each SCK edge is seen exactly once. They also assume that chip-select is high for at least one clock between frames, which is where the latch clear takes effect. The bench drives all pins on the falling edge of `clk`, holds each SCK level for four clocks and each chip-select high gap for six, and lowers SCK before chip-select rises.

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  output logic       req_valid,
  output logic [7:0] req_opcode
);
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_RDSR = 8'h05, OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02, OP_WRSN = 8'hC2, OP_STORE = 8'h3C;
  localparam logic [7:0] OP_RECALL = 8'h60, OP_ASEN = 8'h59, OP_ASDIS = 8'h19;

  typedef enum logic [1:0] {P_OPC, P_RD, P_WR, P_IGN} phase_t;

  phase_t     phase;
  logic       sck_q, wen, wpen, pend_clr;
  logic [1:0] bp;
  logic [2:0] cnt;
  logic [7:0] shreg, rd_sh;

  wire       sck_rise = sck & ~sck_q;
  wire       sck_fall = ~sck & sck_q;
  wire [7:0] sh_next  = {shreg[6:0], mosi};
  wire [7:0] status   = {wpen, 3'b000, bp, wen, 1'b0};
  wire       is_req   = (sh_next == OP_WRITE) || (sh_next == OP_WRSN) || (sh_next == OP_STORE) ||
                        (sh_next == OP_RECALL) || (sh_next == OP_ASEN) || (sh_next == OP_ASDIS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_OPC; sck_q <= 1'b0; wen <= 1'b0; wpen <= 1'b0; pend_clr <= 1'b0;
      bp <= 2'b00; cnt <= 3'd0; shreg <= 8'h00; rd_sh <= 8'h00;
      miso <= 1'b0; miso_oe <= 1'b0; req_valid <= 1'b0; req_opcode <= 8'h00;
    end else begin
      sck_q     <= sck;
      req_valid <= 1'b0;
      if (cs_n) begin
        phase <= P_OPC; cnt <= 3'd0; miso_oe <= 1'b0; miso <= 1'b0;
        if (pend_clr) wen <= 1'b0;
        pend_clr <= 1'b0;
      end else if (sck_rise) begin
        shreg <= sh_next;
        cnt   <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          case (phase)
            P_OPC: begin
              phase <= P_IGN;
              if (sh_next == OP_WREN) wen <= 1'b1;
              else if (sh_next == OP_WRDI) pend_clr <= 1'b1;
              else if (sh_next == OP_RDSR) begin phase <= P_RD; rd_sh <= status; end
              else if (sh_next == OP_WRSR) begin if (wen) phase <= P_WR; end
              else if (is_req && wen) begin
                req_valid <= 1'b1; req_opcode <= sh_next; pend_clr <= 1'b1;
              end
            end
            P_WR: begin
              wpen <= sh_next[7]; bp <= sh_next[3:2]; pend_clr <= 1'b1; phase <= P_IGN;
            end
            default: ;
          endcase
        end
      end else if (sck_fall && phase == P_RD) begin
        miso_oe <= 1'b1;
        miso    <= rd_sh[7];
        rd_sh   <= {rd_sh[6:0], rd_sh[7]};
      end
    end
  end

  a_r8_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  a_r6_req_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> wen);
  a_r6_bp_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $past(wen));
  a_r3_hiz_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !miso_oe);
  a_r3_hiz_in_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_OPC) |-> !miso_oe);
  a_r7_wen_falls_at_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wen) |-> $past(cs_n));
  a_r2_wen_rises_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen) |-> !$past(cs_n));
endmodule

// File: tb/spi_wel_ctrl_tb.sv
module spi_wel_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, req_valid;
  logic [7:0] req_opcode;
  int checks = 0, failures = 0;
  bit done = 0;
  int cs_high_cnt = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  bit m_wen = 0, m_wpen = 0;
  logic [1:0] m_bp = 2'b00;

  always #10 clk = ~clk;

  spi_wel_ctrl dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .req_valid(req_valid), .req_opcode(req_opcode));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && req_valid) got_q.push_back(req_opcode);
    cs_high_cnt = cs_n ? cs_high_cnt + 1 : 0;
    if (rst_n && cs_high_cnt >= 2) chk("R3 oe while cs high", miso_oe, 0);
  end

  function automatic logic [7:0] m_status();
    return {m_wpen, 3'b000, m_bp, m_wen, 1'b0};
  endfunction

  task automatic cs_lo();
    cs_n = 1'b0; repeat (4) @(negedge clk);
  endtask
  task automatic cs_hi();
    sck = 1'b0; repeat (4) @(negedge clk);
    cs_n = 1'b1; repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [7:0] d, output logic [7:0] rx, output int oe_sum);
    rx = 8'h00; oe_sum = 0;
    for (int i = 0; i < n; i++) begin
      mosi = d[7-i]; sck = 1'b0; repeat (4) @(negedge clk);
      rx = {rx[6:0], miso}; oe_sum += miso_oe;
      sck = 1'b1; repeat (4) @(negedge clk);
    end
  endtask

  task automatic rdsr(input string tag);
    logic [7:0] rx; int oe;
    cs_lo();
    xfer(8, 8'h05, rx, oe);
    chk({tag, " R3 hiz in opcode"}, oe, 0);
    xfer(8, 8'h00, rx, oe);
    chk({tag, " R3 oe in data"}, oe, 8);
    chk({tag, " R4 status"}, rx, m_status());
    cs_hi();
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rx; int oe;
    cs_lo(); xfer(8, op, rx, oe); xfer(8, 8'h06, rx, oe); cs_hi();
    if (op == 8'h06) m_wen = 1;
    else if (op == 8'h04) m_wen = 0;
    else if (op == 8'h02 || op == 8'hC2 || op == 8'h3C || op == 8'h60 || op == 8'h59 || op == 8'h19) begin
      if (m_wen) begin exp_q.push_back(op); m_wen = 0; end
    end
  endtask

  task automatic wrsr(input logic [7:0] d, input int nbits);
    logic [7:0] rx; int oe;
    cs_lo(); xfer(8, 8'h01, rx, oe); xfer(nbits, d, rx, oe); cs_hi();
    if (m_wen && nbits == 8) begin m_wpen = d[7]; m_bp = d[3:2]; m_wen = 0; end
  endtask

  task automatic chk_reqs(input string tag);
    chk({tag, " request count"}, got_q.size(), exp_q.size());
    while (got_q.size() > 0 && exp_q.size() > 0)
      chk({tag, " request opcode"}, got_q.pop_front(), exp_q.pop_front());
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx; int oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 oe after reset", miso_oe, 0);
    chk("R1 req after reset", req_valid, 0);
    rdsr("R1 reset");

    cmd(8'h06); rdsr("R2 after enable");
    cmd(8'h04); rdsr("R2 after disable");

    wrsr(8'hFF, 8); rdsr("R6 status write blocked");
    cmd(8'h3C); chk_reqs("R6 store blocked");
    cmd(8'h02); chk_reqs("R6 write blocked");

    cmd(8'h06); wrsr(8'hFF, 8); rdsr("R5 R7 status write ones");
    cmd(8'h06); wrsr(8'h73, 8); rdsr("R5 dont-care bits");
    cmd(8'h06); wrsr(8'h88, 8); rdsr("R5 pattern 88");

    cmd(8'h06); cmd(8'h02); chk_reqs("R8 array write"); rdsr("R7 after write");
    foreach (exp_q[i]) ;
    cmd(8'h06); cmd(8'hC2); chk_reqs("R8 serial write");
    cmd(8'h06); cmd(8'h3C); chk_reqs("R8 store");
    cmd(8'h06); cmd(8'h60); chk_reqs("R8 recall");
    cmd(8'h06); cmd(8'h59); chk_reqs("R8 autostore enable");
    cmd(8'h06); cmd(8'h19); chk_reqs("R8 autostore disable");
    rdsr("R7 after specials");

    cmd(8'h06); wrsr(8'h00, 4); rdsr("R9 data abort");
    cs_lo(); xfer(6, 8'h04, rx, oe); cs_hi(); rdsr("R9 disable abort keeps latch");
    wrsr(8'h00, 8); rdsr("R5 clear fields");
    cs_lo(); xfer(5, 8'h06, rx, oe); cs_hi(); rdsr("R9 enable abort");

    cs_lo(); xfer(8, 8'hAA, rx, oe); xfer(8, 8'h06, rx, oe); cs_hi();
    rdsr("R10 unknown opcode ignored");
    cs_lo(); xfer(8, 8'h01, rx, oe); xfer(8, 8'h06, rx, oe); xfer(8, 8'h06, rx, oe); cs_hi();
    rdsr("R6 frame ignored after blocked write");
    cs_lo(); xfer(8, 8'h06, rx, oe); xfer(8, 8'h02, rx, oe); cs_hi(); m_wen = 1;
    chk_reqs("R10 byte after enable ignored");
    rdsr("R10 latch set");
    cmd(8'h04); rdsr("R2 disable again");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule